// File: doc/BRIEF.md
# Dual-Track CIC Decimator

This block lowers the sample rate of a pair of matched streams, one carrying the in-phase (real) component and one the quadrature (imaginary) component of a signal. Each stream enters as a narrow two's complement word on every clock. A single-stage cascaded integrator-comb filter decimates it. The integrator accumulates at the full input rate. The comb takes the difference of successive integrator snapshots at the reduced rate, so each decimated result is the sum of one frame of `DECIM` consecutive input samples.

One phase counter is shared by both tracks. It decides when a frame closes, so the real and imaginary outputs always describe the same frame and update on the same clock. All arithmetic inside the filter keeps full precision and wraps modulo the accumulator width, which is the input width plus `ceil(log2(DECIM))`.

Each result then leaves the block through a saturating window reducer. The position of the window inside the wide word is chosen by a parameter. Values that fit the window are truncated toward negative infinity. Values that do not fit are clamped to the largest or smallest output code. This arrangement allows a downstream stage to trade headroom for resolution near zero.

Top module: `iqcic_decim`

## Requirements
- R1: While the synchronous reset `rst` is high at a clock edge, the integrators, comb delays and phase counter are cleared, so both outputs read zero and `outValid` is low; input samples presented during reset do not contribute to any later result.
- R2: After reset is released, `outValid` is high for exactly one cycle after every `DECIM` input samples. The first pulse is visible in the cycle after the clock edge that consumed the `DECIM`-th sample following reset.
- R3: For a frame whose two's complement sample sum S lies in [-2^WIN_MSB, 2^WIN_MSB - 1], the output code equals floor(S / 2^(WIN_MSB - OUT_W + 1)), which is bits WIN_MSB down to WIN_MSB - OUT_W + 1 of S.
- R4: For a frame with S greater than 2^WIN_MSB - 1, the output is the largest positive code 2^(OUT_W-1) - 1.
- R5: For a frame with S less than -2^WIN_MSB, the output is the most negative code -2^(OUT_W-1).
- R6: The real and imaginary tracks share one frame timing, and the data of one track has no effect on the output of the other.
- R7: Between valid pulses, both outputs hold the value of the last completed frame.
- R8: Wrap-around of the integrator over many frames does not disturb the results: every frame still yields the sum of its own samples.
- R9: A reset raised in the middle of a frame discards that partial frame. The next frame starts with the first sample after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input-rate clock; one sample per track per cycle |
| rst | input | 1 | Synchronous reset, active high |
| inRe | input | IN_W | In-phase input sample, two's complement |
| inIm | input | IN_W | Quadrature input sample, two's complement |
| outRe | output | OUT_W | Decimated, window-reduced in-phase result |
| outIm | output | OUT_W | Decimated, window-reduced quadrature result |
| outValid | output | 1 | One-cycle pulse marking a new decimated pair |

## Verification
The bench builds the block with `DECIM` = 5, `IN_W` = 5, `OUT_W` = 4 and `WIN_MSB` = 5. These values make the accumulator only 8 bits wide, so it wraps within a few frames, and a run of sixty frames crosses the wrap boundary many times. The 6-bit fit range of the window can be exceeded in both directions by five samples of a 5-bit word, so both saturation rails are reachable. The two-bit truncation below the window also exposes the floor rounding of negative sums.

// File: rtl/iqcic_pkg.sv
package iqcic_pkg;

  // Strobes sent from the shared control to every track datapath.
  typedef struct packed {
    logic clear;  // synchronous clear of all track state
    logic dump;   // current sample closes the frame
  } ctlStrobe_t;

endpackage

// File: rtl/iqcic_ctrl.sv
module iqcic_ctrl
  import iqcic_pkg::*;
#(
  parameter int DECIM = 1250
) (
  input  logic       clk,
  input  logic       rst,
  output ctlStrobe_t strobes,
  output logic       outValid
);

  localparam int CNT_W = (DECIM > 1) ? $clog2(DECIM) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DECIM - 1);

  logic [CNT_W-1:0] phase;
  logic             lastPhase;

  assign lastPhase = (phase == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase    <= '0;
      outValid <= 1'b0;
    end else begin
      phase    <= lastPhase ? '0 : phase + 1'b1;
      outValid <= lastPhase;
    end
  end

  assign strobes.clear = rst;
  assign strobes.dump  = lastPhase & ~rst;

  // R2
  phase_range_chk: assert property (@(posedge clk) disable iff (rst)
    phase <= LAST);

  // R2
  valid_align_chk: assert property (@(posedge clk) disable iff (rst)
    outValid |-> (phase == '0));

  generate
    if (DECIM > 1) begin : g_pulse
      // R2
      valid_single_chk: assert property (@(posedge clk) disable iff (rst)
        outValid |=> !outValid);
    end
  endgenerate

endmodule

// File: rtl/iqcic_window.sv
module iqcic_window #(
  parameter int IN_W  = 16,
  parameter int OUT_W = 8,
  parameter int TOP   = 13
) (
  input  logic [IN_W-1:0]  wide,
  output logic [OUT_W-1:0] narrow
);

  localparam int LOW = TOP - OUT_W + 1;
  localparam logic [OUT_W-1:0] MAX_CODE = {1'b0, {(OUT_W-1){1'b1}}};
  localparam logic [OUT_W-1:0] MIN_CODE = {1'b1, {(OUT_W-1){1'b0}}};

  generate
    if (TOP == IN_W - 1) begin : g_top
      assign narrow = wide[TOP:LOW];
    end else begin : g_sat
      logic [IN_W-1-TOP:0] headBits;
      logic                fits;
      assign headBits = wide[IN_W-1:TOP];
      assign fits     = (&headBits) | ~(|headBits);
      assign narrow   = fits ? wide[TOP:LOW]
                             : (wide[IN_W-1] ? MIN_CODE : MAX_CODE);
    end

    if (LOW > 0) begin : g_low
      logic unusedLow;
      assign unusedLow = ^wide[LOW-1:0];
    end
  endgenerate

endmodule

// File: rtl/iqcic_track.sv
module iqcic_track
  import iqcic_pkg::*;
#(
  parameter int IN_W    = 5,
  parameter int ACC_W   = 16,
  parameter int OUT_W   = 8,
  parameter int WIN_MSB = 13
) (
  input  logic             clk,
  input  ctlStrobe_t       strobes,
  input  logic [IN_W-1:0]  sample,
  output logic [OUT_W-1:0] outSample
);

  logic [ACC_W-1:0] integ;
  logic [ACC_W-1:0] combDelay;
  logic [ACC_W-1:0] accNext;
  logic [ACC_W-1:0] combOut;
  logic [OUT_W-1:0] narrowed;

  assign accNext = integ + ACC_W'($signed(sample));
  assign combOut = accNext - combDelay;

  iqcic_window #(
    .IN_W (ACC_W),
    .OUT_W(OUT_W),
    .TOP  (WIN_MSB)
  ) u_window (
    .wide  (combOut),
    .narrow(narrowed)
  );

  always_ff @(posedge clk) begin
    if (strobes.clear) begin
      integ     <= '0;
      combDelay <= '0;
      outSample <= '0;
    end else begin
      integ <= accNext;
      if (strobes.dump) begin
        combDelay <= accNext;
        outSample <= narrowed;
      end
    end
  end

  // R7
  out_hold_chk: assert property (@(posedge clk) disable iff (strobes.clear)
    !strobes.dump |=> $stable(outSample));

  // R8
  delay_hold_chk: assert property (@(posedge clk) disable iff (strobes.clear)
    !strobes.dump |=> $stable(combDelay));

  // R4
  sign_keep_chk: assert property (@(posedge clk) disable iff (strobes.clear)
    strobes.dump |=> (outSample[OUT_W-1] == $past(combOut[ACC_W-1])));

endmodule

// File: rtl/iqcic_decim.sv
module iqcic_decim
  import iqcic_pkg::*;
#(
  parameter int DECIM   = 1250,
  parameter int IN_W    = 5,
  parameter int OUT_W   = 8,
  parameter int WIN_MSB = 13
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IN_W-1:0]  inRe,
  input  logic [IN_W-1:0]  inIm,
  output logic [OUT_W-1:0] outRe,
  output logic [OUT_W-1:0] outIm,
  output logic             outValid
);

  localparam int ACC_W   = IN_W + $clog2(DECIM);
  localparam int N_TRACK = 2;

  ctlStrobe_t strobes;
  logic [N_TRACK-1:0][IN_W-1:0]  trackIn;
  logic [N_TRACK-1:0][OUT_W-1:0] trackOut;

  assign trackIn[0] = inRe;
  assign trackIn[1] = inIm;
  assign outRe      = trackOut[0];
  assign outIm      = trackOut[1];

  iqcic_ctrl #(
    .DECIM(DECIM)
  ) u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .strobes (strobes),
    .outValid(outValid)
  );

  generate
    for (genvar t = 0; t < N_TRACK; t++) begin : g_track
      iqcic_track #(
        .IN_W   (IN_W),
        .ACC_W  (ACC_W),
        .OUT_W  (OUT_W),
        .WIN_MSB(WIN_MSB)
      ) u_track (
        .clk      (clk),
        .strobes  (strobes),
        .sample   (trackIn[t]),
        .outSample(trackOut[t])
      );
    end
  endgenerate

endmodule

// File: tb/iqcic_decim_test.sv
`timescale 1ns/1ps
module iqcic_decim_test;

  localparam int DECIM   = 5;
  localparam int IN_W    = 5;
  localparam int OUT_W   = 4;
  localparam int WIN_MSB = 5;
  localparam int N_VEC   = 9;

  // columns: real sample, imaginary sample (held for a whole frame),
  // expected real code, expected imaginary code
  localparam int VEC [N_VEC][4] = '{
    '{ 1, -1,  1, -2},  // R3: small sums, floor on negative
    '{ 6, -6,  7, -8},  // R3: fit-range edges (30, -30)
    '{ 7, -7,  7, -8},  // R4 R5: 35 and -35 clamp
    '{15,-16,  7, -8},  // R4 R5: extreme inputs clamp
    '{ 0,  3,  0,  3},  // R3
    '{-3,  2, -4,  2},  // R3
    '{ 4,  4,  5,  5},  // R3
    '{-6,  6, -8,  7},  // R3
    '{-7,  0, -8,  0}   // R5
  };

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic [IN_W-1:0]  inRe = '0;
  logic [IN_W-1:0]  inIm = '0;
  logic [OUT_W-1:0] outRe;
  logic [OUT_W-1:0] outIm;
  logic             outValid;

  int tests = 0;
  int fails = 0;
  int frameRe [DECIM];
  int frameIm [DECIM];

  always #4 clk = ~clk;

  iqcic_decim #(
    .DECIM(DECIM), .IN_W(IN_W), .OUT_W(OUT_W), .WIN_MSB(WIN_MSB)
  ) uut (
    .clk(clk), .rst(rst), .inRe(inRe), .inIm(inIm),
    .outRe(outRe), .outIm(outIm), .outValid(outValid)
  );

  function automatic int sRe();
    return int'($signed(outRe));
  endfunction

  function automatic int sIm();
    return int'($signed(outIm));
  endfunction

  task automatic chk(string req, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic fillConst(int re, int im);
    for (int i = 0; i < DECIM; i++) begin
      frameRe[i] = re;
      frameIm[i] = im;
    end
  endtask

  // Drives one frame starting at a negedge; checks at the negedge after
  // each consuming posedge.
  task automatic runFrame(int expRe, int expIm, string tag);
    int prevRe = sRe();
    int prevIm = sIm();
    for (int i = 0; i < DECIM; i++) begin
      inRe = IN_W'(frameRe[i]);
      inIm = IN_W'(frameIm[i]);
      @(negedge clk);
      if (i < DECIM - 1) begin
        chk({"R2 valid low mid-frame ", tag}, int'(outValid), 0);
        chk({"R7 real held ", tag}, sRe(), prevRe);
        chk({"R7 imag held ", tag}, sIm(), prevIm);
      end
    end
    chk({"R2 valid pulse ", tag}, int'(outValid), 1);
    chk({"R6 real result ", tag}, sRe(), expRe);
    chk({"R6 imag result ", tag}, sIm(), expIm);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin : main
    // R1: reset with nonzero inputs
    inRe = IN_W'(9);
    inIm = IN_W'(-9);
    repeat (3) @(negedge clk);
    chk("R1 valid in reset", int'(outValid), 0);
    chk("R1 real in reset", sRe(), 0);
    chk("R1 imag in reset", sIm(), 0);
    rst = 1'b0;

    // table walk covering R3, R4, R5 on both tracks
    for (int v = 0; v < N_VEC; v++) begin
      fillConst(VEC[v][0], VEC[v][1]);
      runFrame(VEC[v][2], VEC[v][3], $sformatf("R3 R4 R5 vec%0d", v));
    end

    // R3: mixed samples within a frame: 16 -> 4, -4 -> -1
    frameRe = '{7, 7, 7, -3, -2};
    frameIm = '{-8, 1, 1, 1, 1};
    runFrame(4, -1, "R3 mixed");

    // R6: one track busy, the other idle
    fillConst(15, 0);
    runFrame(7, 0, "R6 real only");
    fillConst(0, -16);
    runFrame(0, -8, "R6 imag only");

    // R8: long run across accumulator wrap: 20 -> 5, -25 -> -7
    for (int f = 0; f < 60; f++) begin
      fillConst(4, -5);
      runFrame(5, -7, "R8 wrap run");
    end

    // R9: reset in the middle of a frame
    inRe = IN_W'(7);
    inIm = IN_W'(7);
    repeat (2) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    chk("R9 valid after mid reset", int'(outValid), 0);
    chk("R9 real cleared", sRe(), 0);
    chk("R9 imag cleared", sIm(), 0);
    rst = 1'b0;
    fillConst(2, -2);
    runFrame(2, -3, "R9 fresh frame");

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule